// File: doc/BRIEF.md
# Transmit Auto-Retry Sequencer

This block runs one frame transmission for a host, retrying on its own. A one-cycle `start` pulse begins a transaction. The sequencer then works through a lower physical layer using three handshakes:

- a channel-assessment request that carries a random backoff count;
- a frame-send request;
- an acknowledgement outcome, either an ACK or a timeout.

A busy channel is retried up to the channel-access limit. An unacknowledged frame is resent up to the frame limit, and each new frame attempt gets a fresh channel-access budget. When the transaction ends, the block latches one 3-bit status code for the host.

An 8-bit control byte holds both limits and a slotted-operation flag. The flag is only stored and read back. A channel-access setting of 7 skips channel assessment, so every frame attempt is sent at once. The reserved setting 6 behaves as 5.

Backoff counts come from a 16-bit LFSR that software can reseed with a byte. Each count is masked to a window that starts at 2^3 and doubles with each failed assessment, up to 2^5.

Top module: `txRetrySeq`

## Requirements
- R1: After reset `cfgByte` is 0x38, `status` is 7, and `busy`, `ccaReq` and `txReq` are all 0.
- R2: `cfgByte` returns the last value written with `cfgWrEn`. Bits 7..4 are the frame-retry limit F, bits 3..1 are the channel-access setting C, and bit 0 is the slotted flag.
- R3: If an acknowledgement is received (`ackDone` with `ackRcvd`=1), the transaction ends with status 0.
- R4: Take C in 0..5. If C+1 assessments in a row report busy within one frame attempt, the transaction ends with status 3 and that frame attempt is not sent.
- R5: Each send that ends with `ackRcvd`=0 starts a new frame attempt with a fresh channel-access budget, up to F+1 sends in total. If the last of these is unacknowledged, the status is 5.
- R6: When C=7, `ccaReq` stays low for the whole transaction and each frame attempt raises `txReq` directly.
- R7: C=6 behaves exactly like C=5, so at most 6 assessments are made per frame attempt.
- R8: `ccaBackoff` equals L[4:0] AND (2^E−1). L is the LFSR state before the draw. E is 3 at the first assessment of each frame attempt, and rises by 1 after each busy result, up to a cap of 5.
- R9: The LFSR is 16 bits and shifts right, Galois style. When the bit shifted out is 1, the new state is XORed with 0xB400. It advances once per draw, and one draw is made before every assessment and, when C=7, before every send. Writing seed byte S loads {~S, S}. The reset state is seed 0xEA, which gives 0x15EA.
- R10: `busy` is high from the cycle after an accepted `start` until the status is latched, and `status` reads 7 while busy. A `start` during busy is ignored. The final status holds until the next transaction.
- R11: F and C are captured when `start` is accepted. Writes to `cfgByte` during a transaction do not change its outcome.
- R12: `ccaReq` and `txReq` are never high together. Each request stays high until its own done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Host transaction request pulse |
| cfgWrEn | input | 1 | Control byte write strobe |
| cfgWrData | input | 8 | Control byte write value |
| seedWrEn | input | 1 | Seed write strobe |
| seedWrData | input | 8 | Seed byte |
| ccaDone | input | 1 | Assessment finished pulse |
| ccaClear | input | 1 | Assessment result, 1 = channel idle |
| txDone | input | 1 | Frame sent pulse |
| ackDone | input | 1 | Acknowledgement outcome pulse |
| ackRcvd | input | 1 | Outcome, 1 = acknowledged, 0 = timeout |
| cfgByte | output | 8 | Control byte readback |
| busy | output | 1 | Transaction in progress |
| status | output | 3 | Final status: 0 ok, 3 channel fail, 5 no ack, 7 none |
| ccaReq | output | 1 | Assessment request |
| ccaBackoff | output | 5 | Backoff count for this assessment |
| txReq | output | 1 | Frame-send request |

## Verification
The hardest case to reach from the ports is the very last allowed attempt. It is the point where both retry limits are fully spent and the backoff window sits at its cap, while the LFSR still has to match after dozens of draws.

The bench reaches it by sweeping every channel-access setting (0 to 7) against frame limits 0 to 2. A responder answers each request with a scripted number of busy results per frame attempt: zero, exactly the limit, or one more than the limit. Acknowledgement arrives on the first attempt, on the last attempt, or never.

A bench-side LFSR and exponent model predicts every backoff count. It is reseeded together with the design at several points.

// File: rtl/txRetryPkg.sv
package txRetryPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAW,
    ST_CCA,
    ST_SEND,
    ST_ACK
  } seqState_t;

  localparam logic [2:0] CODE_OK      = 3'd0;
  localparam logic [2:0] CODE_CHANFAIL = 3'd3;
  localparam logic [2:0] CODE_NOACK   = 3'd5;
  localparam logic [2:0] CODE_NONE    = 3'd7;

  typedef struct packed {
    logic       startTxn;
    logic       draw;
    logic       csmaRetry;
    logic       frameRetry;
    logic       finish;
    logic [2:0] code;
  } seqStrobe_t;

endpackage

// File: rtl/txRetryCtrl.sv
module txRetryCtrl
  import txRetryPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       ccaDone,
  input  logic       ccaClear,
  input  logic       txDone,
  input  logic       ackDone,
  input  logic       ackRcvd,
  input  logic       bypass,
  input  logic       csmaAtLimit,
  input  logic       frameAtLimit,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       ccaReq,
  output logic       txReq
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.startTxn = 1'b1;
          stateNext       = ST_DRAW;
        end
      end
      ST_DRAW: begin
        strobe.draw = 1'b1;
        stateNext   = bypass ? ST_SEND : ST_CCA;
      end
      ST_CCA: begin
        if (ccaDone) begin
          if (ccaClear) begin
            stateNext = ST_SEND;
          end else if (csmaAtLimit) begin
            strobe.finish = 1'b1;
            strobe.code   = CODE_CHANFAIL;
            stateNext     = ST_IDLE;
          end else begin
            strobe.csmaRetry = 1'b1;
            stateNext        = ST_DRAW;
          end
        end
      end
      ST_SEND: begin
        if (txDone) stateNext = ST_ACK;
      end
      ST_ACK: begin
        if (ackDone) begin
          if (ackRcvd) begin
            strobe.finish = 1'b1;
            strobe.code   = CODE_OK;
            stateNext     = ST_IDLE;
          end else if (frameAtLimit) begin
            strobe.finish = 1'b1;
            strobe.code   = CODE_NOACK;
            stateNext     = ST_IDLE;
          end else begin
            strobe.frameRetry = 1'b1;
            stateNext         = ST_DRAW;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy   = (state != ST_IDLE);
  assign ccaReq = (state == ST_CCA);
  assign txReq  = (state == ST_SEND);

  assert_req_mutex_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(ccaReq && txReq));

  assert_cca_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ccaReq && !ccaDone) |=> ccaReq);

  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !txDone) |=> txReq);

endmodule

// File: rtl/txRetryDatapath.sv
module txRetryDatapath
  import txRetryPkg::*;
#(
  parameter int FRAME_W   = 4,
  parameter int CSMA_W    = 3,
  parameter int CFG_W     = 8,
  parameter int SEED_W    = 8,
  parameter int MIN_BE    = 3,
  parameter int MAX_BE    = 5,
  parameter int CSMA_MAX  = 5,
  parameter int CSMA_BYP  = 7,
  parameter int CSMA_RSV  = 6,
  parameter logic [CFG_W-1:0]    CFG_RESET  = 8'h38,
  parameter logic [SEED_W-1:0]   SEED_RESET = 8'hEA,
  parameter logic [2*SEED_W-1:0] LFSR_TAPS  = 16'hB400
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              seedWrEn,
  input  logic [SEED_W-1:0] seedWrData,
  output logic [CFG_W-1:0]  cfgByte,
  output logic              bypass,
  output logic              csmaAtLimit,
  output logic              frameAtLimit,
  output logic [MAX_BE-1:0] ccaBackoff,
  output logic [2:0]        status
);

  localparam int LFSR_W = 2 * SEED_W;
  localparam int BE_W   = $clog2(MAX_BE + 1);
  localparam int CSMA_LSB = 1;
  localparam int FRAME_LSB = CSMA_LSB + CSMA_W;

  logic [CFG_W-1:0]   cfgReg;
  logic [FRAME_W-1:0] frameLimQ, frameCnt;
  logic [CSMA_W-1:0]  csmaLimQ, csmaCnt, csmaField;
  logic               bypassQ;
  logic [BE_W-1:0]    beQ;
  logic [LFSR_W-1:0]  lfsr, lfsrNext;
  logic [MAX_BE-1:0]  beMask;
  logic [2:0]         statusQ;

  assign csmaField = cfgReg[FRAME_LSB-1:CSMA_LSB];

  always_ff @(posedge clk) begin
    if (!rstN)        cfgReg <= CFG_RESET;
    else if (cfgWrEn) cfgReg <= cfgWrData;
  end

  // limits are frozen for the whole transaction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameLimQ <= '0;
      csmaLimQ  <= '0;
      bypassQ   <= 1'b0;
    end else if (strobe.startTxn) begin
      frameLimQ <= cfgReg[FRAME_LSB+FRAME_W-1:FRAME_LSB];
      bypassQ   <= (csmaField == CSMA_W'(CSMA_BYP));
      csmaLimQ  <= (csmaField == CSMA_W'(CSMA_RSV)) ? CSMA_W'(CSMA_MAX) : csmaField;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
      csmaCnt  <= '0;
      beQ      <= BE_W'(MIN_BE);
    end else if (strobe.startTxn) begin
      frameCnt <= '0;
      csmaCnt  <= '0;
      beQ      <= BE_W'(MIN_BE);
    end else if (strobe.frameRetry) begin
      frameCnt <= frameCnt + 1'b1;
      csmaCnt  <= '0;
      beQ      <= BE_W'(MIN_BE);
    end else if (strobe.csmaRetry) begin
      csmaCnt <= csmaCnt + 1'b1;
      if (beQ < BE_W'(MAX_BE)) beQ <= beQ + 1'b1;
    end
  end

  assign csmaAtLimit  = (csmaCnt == csmaLimQ);
  assign frameAtLimit = (frameCnt == frameLimQ);
  assign bypass       = bypassQ;

  always_comb begin
    for (int i = 0; i < MAX_BE; i++) beMask[i] = (BE_W'(i) < beQ);
  end

  assign lfsrNext = (lfsr >> 1) ^ (lfsr[0] ? LFSR_TAPS : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr       <= {~SEED_RESET, SEED_RESET};
      ccaBackoff <= '0;
    end else if (seedWrEn) begin
      lfsr <= {~seedWrData, seedWrData};
    end else if (strobe.draw) begin
      lfsr       <= lfsrNext;
      ccaBackoff <= lfsr[MAX_BE-1:0] & beMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                statusQ <= CODE_NONE;
    else if (strobe.startTxn) statusQ <= CODE_NONE;
    else if (strobe.finish)   statusQ <= strobe.code;
  end

  assign cfgByte = cfgReg;
  assign status  = statusQ;

  assert_csma_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    csmaCnt <= CSMA_W'(CSMA_MAX));

  assert_frame_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= frameLimQ);

  assert_be_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (beQ >= BE_W'(MIN_BE)) && (beQ <= BE_W'(MAX_BE)));

  assert_lfsr_live_R9: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);

endmodule

// File: rtl/txRetrySeq.sv
module txRetrySeq
  import txRetryPkg::*;
#(
  parameter int FRAME_W = 4,
  parameter int CSMA_W  = 3,
  parameter int CFG_W   = 8,
  parameter int SEED_W  = 8,
  parameter int MIN_BE  = 3,
  parameter int MAX_BE  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              seedWrEn,
  input  logic [SEED_W-1:0] seedWrData,
  input  logic              ccaDone,
  input  logic              ccaClear,
  input  logic              txDone,
  input  logic              ackDone,
  input  logic              ackRcvd,
  output logic [CFG_W-1:0]  cfgByte,
  output logic              busy,
  output logic [2:0]        status,
  output logic              ccaReq,
  output logic [MAX_BE-1:0] ccaBackoff,
  output logic              txReq
);

  seqStrobe_t strobe;
  logic bypass, csmaAtLimit, frameAtLimit;

  txRetryCtrl ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ccaDone(ccaDone), .ccaClear(ccaClear),
    .txDone(txDone), .ackDone(ackDone), .ackRcvd(ackRcvd),
    .bypass(bypass), .csmaAtLimit(csmaAtLimit), .frameAtLimit(frameAtLimit),
    .strobe(strobe), .busy(busy), .ccaReq(ccaReq), .txReq(txReq)
  );

  txRetryDatapath #(
    .FRAME_W(FRAME_W), .CSMA_W(CSMA_W), .CFG_W(CFG_W), .SEED_W(SEED_W),
    .MIN_BE(MIN_BE), .MAX_BE(MAX_BE)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .seedWrEn(seedWrEn), .seedWrData(seedWrData),
    .cfgByte(cfgByte), .bypass(bypass),
    .csmaAtLimit(csmaAtLimit), .frameAtLimit(frameAtLimit),
    .ccaBackoff(ccaBackoff), .status(status)
  );

  assert_fin_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (status != CODE_NONE));

  assert_busy_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (status == CODE_NONE));

  assert_bypass_nocca_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bypass) |-> !ccaReq);

endmodule

// File: tb/txRetrySeq_test.sv
module txRetrySeq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 0, cfgWrEn = 0, seedWrEn = 0;
  logic [7:0] cfgWrData = '0, seedWrData = '0;
  logic       ccaDone = 0, ccaClear = 0, txDone = 0, ackDone = 0, ackRcvd = 0;
  logic [7:0] cfgByte;
  logic       busy, ccaReq, txReq;
  logic [2:0] status;
  logic [4:0] ccaBackoff;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [15:0] mLfsr;

  always #5 clk = ~clk;

  txRetrySeq uut (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .seedWrEn(seedWrEn), .seedWrData(seedWrData),
    .ccaDone(ccaDone), .ccaClear(ccaClear),
    .txDone(txDone), .ackDone(ackDone), .ackRcvd(ackRcvd),
    .cfgByte(cfgByte), .busy(busy), .status(status),
    .ccaReq(ccaReq), .ccaBackoff(ccaBackoff), .txReq(txReq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired: cycles=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsrStep(input logic [15:0] v);
    return (v >> 1) ^ (v[0] ? 16'hB400 : 16'h0000);
  endfunction

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk); cfgWrEn = 1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 0;
  endtask

  task automatic writeSeed(input logic [7:0] s);
    @(negedge clk); seedWrEn = 1; seedWrData = s;
    @(negedge clk); seedWrEn = 0;
    mLfsr = {~s, s};
  endtask

  // nFail: busy assessments per frame attempt before a clear one
  // ackOn: frame attempt index that is acknowledged, -1 for never
  task automatic runTxn(input int fl, input int cs, input int nFail, input int ackOn,
                        input bit mid);
    int effLim, expStatus, expCca, expTx, ccaCnt, txCnt, inAttempt, be, guard;
    bit byp, done, midDone;
    logic [7:0] cfgVal;
    effLim = (cs == 6) ? 5 : cs;
    byp = (cs == 7);
    expCca = 0; expTx = 0; expStatus = 7; done = 0;
    for (int f = 0; f <= fl && !done; f++) begin
      if (!byp) begin
        if (nFail > effLim) begin
          expCca += effLim + 1; expStatus = 3; done = 1;
        end else expCca += nFail + 1;
      end
      if (!done) begin
        expTx++;
        if (f == ackOn) begin expStatus = 0; done = 1; end
        else if (f == fl) begin expStatus = 5; done = 1; end
      end
    end
    cfgVal = {4'(fl), 3'(cs), 1'b1};
    writeCfg(cfgVal);
    check("R2 cfg readback", int'(cfgByte), int'(cfgVal));
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check("R10 busy after start", int'(busy), 1);
    check("R10 status none while busy", int'(status), 7);
    ccaCnt = 0; txCnt = 0; inAttempt = 0; be = 3; guard = 0; midDone = 0;
    while (busy && guard < 4000) begin
      guard++;
      if (ccaReq) begin
        check("R12 no tx during cca", int'(txReq), 0);
        check("R8 R9 backoff", int'(ccaBackoff), int'(mLfsr[4:0] & 5'((1 << be) - 1)));
        mLfsr = lfsrStep(mLfsr);
        ccaCnt++;
        ccaDone = 1; ccaClear = (inAttempt >= nFail);
        if (inAttempt < nFail && be < 5) be++;
        inAttempt++;
        if (mid && !midDone) begin
          start = 1; cfgWrEn = 1; cfgWrData = 8'h00; midDone = 1;
        end
        @(negedge clk); ccaDone = 0; ccaClear = 0; start = 0; cfgWrEn = 0;
      end else if (txReq) begin
        if (byp) mLfsr = lfsrStep(mLfsr);
        txCnt++;
        txDone = 1;
        if (mid && !midDone) begin
          start = 1; cfgWrEn = 1; cfgWrData = 8'h00; midDone = 1;
        end
        @(negedge clk); txDone = 0; start = 0; cfgWrEn = 0;
        ackDone = 1; ackRcvd = ((txCnt - 1) == ackOn);
        @(negedge clk); ackDone = 0; ackRcvd = 0;
        inAttempt = 0; be = 3;
      end else begin
        @(negedge clk);
      end
    end
    check("R10 transaction ends", int'(busy), 0);
    check("R3 R4 R5 R7 R11 final status", int'(status), expStatus);
    check("R4 R6 R7 assessment count", ccaCnt, expCca);
    check("R5 R6 send count", txCnt, expTx);
    repeat (2) @(negedge clk);
    check("R10 start during busy ignored", int'(busy), 0);
    check("R10 status held", int'(status), expStatus);
  endtask

  initial begin
    mLfsr = 16'h15EA;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 cfg reset", int'(cfgByte), 8'h38);
    check("R1 status reset", int'(status), 7);
    check("R1 busy reset", int'(busy), 0);
    check("R1 ccaReq reset", int'(ccaReq), 0);
    check("R1 txReq reset", int'(txReq), 0);
    // first run uses the reset seed and reset limits F=3, C=4
    runTxn(3, 4, 2, 1, 0);
    for (int fl = 0; fl <= 2; fl++) begin
      if (fl == 1) writeSeed(8'h00);
      if (fl == 2) writeSeed(8'h5C);
      for (int cs = 0; cs <= 7; cs++) begin
        for (int p = 0; p < 3; p++) begin
          for (int a = 0; a < 3; a++) begin
            int eff, nf, ak;
            eff = (cs == 6) ? 5 : cs;
            nf = (p == 0) ? 0 : (p == 1) ? eff : eff + 1;
            ak = (a == 0) ? 0 : (a == 1) ? fl : -1;
            runTxn(fl, cs, nf, ak, ((cs + p + a) % 4) == 0);
          end
        end
      end
    end
    // largest frame limit with the full backoff cap reached each attempt
    runTxn(15, 5, 5, -1, 1);
    runTxn(4, 6, 6, -1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule